// File: doc/BRIEF.md
# Scaled Delayed Feedback Datapath

This block turns a pair of 12-bit unsigned converter samples into one 16-bit output code for a digital-to-analog converter. The first channel runs through a tapped delay line whose length is chosen in clock cycles (0 to 255). The delayed value is then multiplied by a 5-bit fixed-point gain with four fraction bits. The scaled value is added to, or subtracted from, a second operand. That operand is either zero or the second channel, registered once so that it arrives together with the scaler output.

The signed result is saturated to the 12-bit range and placed in the upper bits of the 16-bit code. A sample pair is marked by a one-cycle strobe, nominally every 18 cycles. The gain, delay, operand select and mode are all captured on the strobe cycle. The output code and its strobe follow two cycles later, and the code then holds until the next result.

Top module: `fbk_mix`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release until the first result, out_code is 0 and out_vld is 0.
- R2: out_vld pulses high for one cycle exactly two clock cycles after each cycle in which in_vld is high, and is low otherwise.
- R3: The first-channel value used for a strobe is the chan_a value present dly_cyc cycles before the strobe cycle. dly_cyc = 0 uses the value on the strobe cycle itself. History from before reset release reads as 0.
- R4: The scaled value is floor(a × gain / 16) modulo 4096. Gain 16 is unity, 8 is one half, 15 is 0.9375 and 0 gives 0. Gains 17 to 31 are accepted but wrap (for example 4095 × 17 gives 254).
- R5: With use_b = 1 the second operand is chan_b on the strobe cycle. With use_b = 0 it is 0.
- R6: add_mode = 1 forms operand + scaled. add_mode = 0 forms operand − scaled.
- R7: The signed result is clamped to the range 0 to 4095. out_code equals the clamped value shifted left by 4, so bits [3:0] are always 0.
- R8: out_code holds its value on every cycle on which out_vld is low.
- R9: dly_cyc, gain, use_b, add_mode and chan_b take effect only on strobe cycles. Their values on other cycles have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Strobe marking a new sample pair |
| chan_a | input | 12 | First converter channel, delayed and scaled |
| chan_b | input | 12 | Second converter channel, optional operand |
| dly_cyc | input | 8 | Delay of the first channel in clock cycles |
| gain | input | 5 | Gain with 4 fraction bits |
| use_b | input | 1 | 1: operand is chan_b, 0: operand is zero |
| add_mode | input | 1 | 1: add scaled value, 0: subtract it |
| out_code | output | 16 | Output code for the converter |
| out_vld | output | 1 | Strobe for a new out_code |

## Verification
The scaler's modulo wrap and the output saturation can both act on the same result. A gain above 16 can wrap a large product down to a small value, and a subtraction or addition can then push the sum past either end of the 12-bit range. Directed strobes with gains of 17 and 31 on full-scale samples, together with random gains over the whole 0 to 31 span, provoke this combination. The bench model applies the wrap first and the clamp second, and the expected code must match on the exact cycle of out_vld. Between strobes the controls carry random values, so a design that picks them up on the wrong cycle is exposed by the same comparison.

// File: rtl/fbk_mix.sv
module fbk_mix #(
  parameter int SW   = 12,
  parameter int FW   = 5,
  parameter int FRAC = 4,
  parameter int DW   = 8,
  parameter int OW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [SW-1:0] chan_a,
  input  logic [SW-1:0] chan_b,
  input  logic [DW-1:0] dly_cyc,
  input  logic [FW-1:0] gain,
  input  logic          use_b,
  input  logic          add_mode,
  output logic [OW-1:0] out_code,
  output logic          out_vld
);
  localparam int TAPS = (1 << DW) - 1;
  localparam int PW   = SW + FW;
  localparam int RW   = SW + 2;
  localparam logic signed [RW-1:0] TOP = RW'((1 << SW) - 1);

  logic [SW-1:0] line [TAPS];
  logic [SW-1:0] tap;
  logic [PW-1:0] prod;
  logic          s1_vld, s1_add;
  logic [SW-1:0] s1_scl, s1_opb;
  logic signed [RW-1:0] sum;
  logic [SW-1:0] sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) line[i] <= '0;
    end else begin
      line[0] <= chan_a;
      for (int i = 1; i < TAPS; i++) line[i] <= line[i-1];
    end
  end

  assign tap  = (dly_cyc == '0) ? chan_a : line[dly_cyc - DW'(1)];
  assign prod = PW'(tap) * PW'(gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_add <= 1'b0;
      s1_scl <= '0;
      s1_opb <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_add <= add_mode;
        s1_scl <= prod[FRAC +: SW];
        s1_opb <= use_b ? chan_b : '0;
      end
    end
  end

  assign sum = s1_add ? $signed({2'b00, s1_opb}) + $signed({2'b00, s1_scl})
                      : $signed({2'b00, s1_opb}) - $signed({2'b00, s1_scl});
  assign sat = (sum < 0) ? '0 : (sum > TOP) ? '1 : sum[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_code <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) out_code <= {sat, {(OW-SW){1'b0}}};
    end
  end

  assert_vld_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##2 out_vld);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_code));

  assert_zero_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && gain == '0 && !use_b) |-> ##2 (out_code == '0));

  assert_zero_opnd_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !use_b && !add_mode) |-> ##2 (out_code == '0));

  assert_add_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && use_b && add_mode) |-> ##2 (out_code >= {$past(chan_b, 2), {(OW-SW){1'b0}}}));

  assert_sub_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && use_b && !add_mode) |-> ##2 (out_code <= {$past(chan_b, 2), {(OW-SW){1'b0}}}));
endmodule

// File: tb/sim_fbk_mix.sv
`timescale 1ns/1ps
module sim_fbk_mix;
  localparam int NC = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [11:0] chan_a = '0, chan_b = '0;
  logic [7:0] dly_cyc = '0;
  logic [4:0] gain = '0;
  logic use_b = 1'b0, add_mode = 1'b0;
  logic [15:0] out_code;
  logic out_vld;

  int total = 0, bad = 0, j = 0;
  bit fin = 0;
  logic [11:0] hist [NC];
  bit exp_v [NC];
  logic [15:0] exp_c [NC];
  string exp_t [NC];
  logic [15:0] cur = '0;

  always #2 clk = ~clk;

  fbk_mix u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .chan_a(chan_a),
    .chan_b(chan_b), .dly_cyc(dly_cyc), .gain(gain), .use_b(use_b),
    .add_mode(add_mode), .out_code(out_code), .out_vld(out_vld));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, j, act, exp);
    end
  endtask

  function automatic logic [11:0] hist_at(input int k);
    return (k < 0) ? 12'd0 : hist[k];
  endfunction

  function automatic int model(input logic [11:0] a, input logic [4:0] f,
                               input bit m, input bit ub, input logic [11:0] b,
                               output bit clamped);
    int s, op, r;
    s  = ((int'(a) * int'(f)) >> 4) % 4096;
    op = ub ? int'(b) : 0;
    r  = m ? op + s : op - s;
    clamped = (r < 0) || (r > 4095);
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r * 16;
  endfunction

  task automatic cyc(input bit v, input logic [11:0] a, input logic [11:0] b,
                     input logic [7:0] d, input logic [4:0] f, input bit m,
                     input bit ub, input string tag);
    bit cl;
    int e;
    @(negedge clk);
    if (j >= 2) begin
      if (exp_v[j-2]) begin
        cur = exp_c[j-2];
        chk("R2", 16'(out_vld), 16'd1);
        chk(exp_t[j-2], out_code, cur);
      end else begin
        chk("R2", 16'(out_vld), 16'd0);
        chk("R8", out_code, cur);
      end
    end else begin
      chk("R1", 16'(out_vld), 16'd0);
      chk("R1", out_code, 16'd0);
    end
    in_vld = v; chan_a = a; chan_b = b; dly_cyc = d; gain = f;
    add_mode = m; use_b = ub;
    hist[j] = a;
    exp_v[j] = v;
    if (v) begin
      e = model(hist_at(j - int'(d)), f, m, ub, b, cl);
      exp_c[j] = 16'(e);
      exp_t[j] = cl ? "R7" : tag;
    end
    j++;
  endtask

  task automatic period(input logic [7:0] d, input logic [4:0] f, input bit m,
                        input bit ub, input logic [11:0] a, input logic [11:0] b,
                        input bit vary, input string tag);
    for (int i = 0; i < 17; i++)
      cyc(1'b0, vary ? 12'($urandom) : a, 12'($urandom), 8'($urandom),
          5'($urandom), 1'($urandom), 1'($urandom), tag);
    cyc(1'b1, vary ? 12'($urandom) : a, b, d, f, m, ub, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) begin
      @(negedge clk);
      chk("R1", out_code, 16'd0);
      chk("R1", 16'(out_vld), 16'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R4 gain points, including wrap above 16
    period(8'd0, 5'd16, 1'b1, 1'b0, 12'd2748, 12'd0, 1'b0, "R4");
    period(8'd0, 5'd8,  1'b1, 1'b0, 12'd4095, 12'd0, 1'b0, "R4");
    period(8'd3, 5'd15, 1'b1, 1'b0, 12'd16,   12'd0, 1'b0, "R4");
    period(8'd0, 5'd17, 1'b1, 1'b0, 12'd4095, 12'd0, 1'b0, "R4");
    period(8'd0, 5'd31, 1'b1, 1'b0, 12'd4095, 12'd0, 1'b0, "R4");
    period(8'd0, 5'd0,  1'b1, 1'b0, 12'd4095, 12'd0, 1'b0, "R4");
    // R5 operand select
    period(8'd0, 5'd0,  1'b1, 1'b1, 12'd50,  12'd100,  1'b0, "R5");
    period(8'd0, 5'd16, 1'b1, 1'b0, 12'd100, 12'd4000, 1'b0, "R5");
    // R6 subtract
    period(8'd0, 5'd16, 1'b0, 1'b1, 12'd1000, 12'd3000, 1'b0, "R6");
    // R7 saturation both ways, and wrap followed by clamp
    period(8'd0, 5'd16, 1'b1, 1'b1, 12'd4000, 12'd4000, 1'b0, "R7");
    period(8'd0, 5'd16, 1'b0, 1'b1, 12'd4000, 12'd10,   1'b0, "R7");
    period(8'd0, 5'd31, 1'b0, 1'b1, 12'd4095, 12'd100,  1'b0, "R7");
    period(8'd0, 5'd17, 1'b1, 1'b1, 12'd4095, 12'd4000, 1'b0, "R7");
    // R3 delay with a changing first channel
    period(8'd1,   5'd16, 1'b1, 1'b0, 12'd0, 12'd0, 1'b1, "R3");
    period(8'd17,  5'd16, 1'b1, 1'b0, 12'd0, 12'd0, 1'b1, "R3");
    period(8'd18,  5'd16, 1'b1, 1'b0, 12'd0, 12'd0, 1'b1, "R3");
    period(8'd100, 5'd16, 1'b1, 1'b0, 12'd0, 12'd0, 1'b1, "R3");
    for (int k = 0; k < 16; k++) period(8'd255, 5'd16, 1'b1, 1'b0, 12'd0, 12'd0, 1'b1, "R3");
    // R9 controls scrambled between strobes, fixed on the strobe
    period(8'd0, 5'd8, 1'b1, 1'b1, 12'd2000, 12'd1000, 1'b0, "R9");
    period(8'd0, 5'd8, 1'b0, 1'b1, 12'd2000, 12'd3000, 1'b0, "R9");
    // random mix over the full gain range
    for (int k = 0; k < 250; k++)
      period(8'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
             12'($urandom), 12'($urandom), 1'b1, "R6");
    repeat (4) cyc(1'b0, 12'd0, 12'd0, 8'd0, 5'd0, 1'b0, 1'b0, "R8");
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule